// File: doc/BRIEF.md
# Dirty-Page Display Update Scanner

This block walks the per-page dirty flags of a frame buffer whose line pitch is fixed. With that pitch, one page of the 8-bit pixel plane holds exactly four scanlines. After a start pulse the scanner steps through the pages one per cycle, from line 0 up to the configured height. For each page it asks an external dirty-flag store for three flags: the 8-bit page, the matching 24-bit direct-colour page and the matching control-plane page. The last two planes use pages four times larger, so the same step index addresses all three. Consecutive dirty steps are merged into one update rectangle that spans the full screen width. The rectangle is given as a start line and a line count and is handed to a display refresher through a valid/ready handshake.

While it scans, the block records the lowest and highest dirty pages. When the scan is over and at least one page was dirty, it issues a single clear request for that inclusive page span. The request also reports whether the 24-bit planes were in use, so the flag store can clear every plane that took part. A one-cycle done pulse closes the scan. The depth mode and the height are captured at the start pulse and hold for the whole scan.

Top module: `dirty_scan`

## Requirements
- R1: While reset is held and in the first cycle after it, `q_valid`, `upd_valid`, `clr_valid` and `done` are all 0.
- R2: A scan of height H queries pages 0, 1, ..., ceil(H/4)-1 in increasing order, each exactly once, and `q_valid` is high only for those queries.
- R3: A step counts as dirty when `dirty8` is 1, or when the scan runs in 24-bit mode (`mode24_in` = 1 at start) and `dirty24` or `dirtyc` is 1. In 8-bit mode (`mode24_in` = 0), `dirty24` and `dirtyc` have no effect.
- R4: When a dirty run that began at page P is followed by a clean page C, one update is issued with `upd_line` = 4*P and `upd_lines` = 4*(C-P).
- R5: A run still open after the last page (page N-1, where N = ceil(H/4)) is issued as a final update with `upd_line` = 4*P and `upd_lines` = 4*N-4*P.
- R6: While `upd_valid` is 1 and `upd_ready` is 0, the update fields stay unchanged and no page is queried.
- R7: After the last update, if any step was dirty, `clr_valid` is 1 for exactly one cycle, with `clr_lo` and `clr_hi` equal to the lowest and highest dirty pages and `clr_mode24` equal to the sampled mode. If no step was dirty, no clear request is issued.
- R8: Each scan ends with `done` high for exactly one cycle, after every update of the scan. A `start` pulse that arrives during a scan is ignored.
- R9: Changes to `height_in` or `mode24_in` after the start pulse do not affect the running scan.
- R10: A height of 0 produces no query, no update and no clear request, only the done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a scan when the block is idle |
| mode24_in | input | 1 | 1 = 24-bit mode (all three planes), 0 = 8-bit plane only |
| height_in | input | LINE_W | Screen height in lines |
| q_valid | output | 1 | A dirty-flag query is active this cycle |
| q_page | output | LINE_W-2 | Page index being queried |
| dirty8 | input | 1 | Dirty flag of the 8-bit page, combinational answer to `q_page` |
| dirty24 | input | 1 | Dirty flag of the 24-bit page for the same step |
| dirtyc | input | 1 | Dirty flag of the control-plane page for the same step |
| upd_valid | output | 1 | Update rectangle offered |
| upd_ready | input | 1 | Consumer accepts the update |
| upd_line | output | LINE_W | First line of the update |
| upd_lines | output | LINE_W+1 | Number of lines in the update |
| clr_valid | output | 1 | Clear request, one cycle |
| clr_lo | output | LINE_W-2 | Lowest dirty page |
| clr_hi | output | LINE_W-2 | Highest dirty page |
| clr_mode24 | output | 1 | Clear the 24-bit and control planes as well |
| done | output | 1 | Scan finished, one cycle |

## Verification
The start pulse is taken at one rising edge. Page 0 is on `q_page` right after that edge, and each later page follows one edge after the previous one, except while an update is stalled. An update is registered at the edge that evaluates the clean page or the end of the scan. It is offered from that edge until the edge at which `upd_ready` is seen high. The clear pulse, and then the done pulse, each take one more edge. The bench drives inputs so that they settle well before the sampling edge, and it samples every output at the falling edge, half a period after the edge that set it. That one sampling point serves all of these latencies, and the checks compare whole sequences of queries and updates, not absolute cycle numbers.

// File: rtl/dirty_scan_pkg.sv
package dirty_scan_pkg;

    // One 8-bit page at the fixed pitch holds 2**PAGE_LINE_LOG2 scanlines.
    localparam int PAGE_LINE_LOG2 = 2;
    localparam int LINES_PER_PAGE = 1 << PAGE_LINE_LOG2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_EMIT,
        S_CLEAR,
        S_DONE
    } scan_state_t;

endpackage

// File: rtl/dirty_scan_merge.sv
module dirty_scan_merge (
    input  logic mode24,
    input  logic d8,
    input  logic d24,
    input  logic dc,
    output logic dirty
);
    // The larger planes count only when the scan was started in 24-bit mode.
    always_comb begin
        dirty = d8 | (mode24 & (d24 | dc));
    end
endmodule

// File: rtl/dirty_scan_span.sv
module dirty_scan_span #(
    parameter int PAGE_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              hit,
    input  logic [PAGE_W-1:0] page,
    output logic              any,
    output logic [PAGE_W-1:0] lo,
    output logic [PAGE_W-1:0] hi
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            any <= 1'b0;
            lo  <= '0;
            hi  <= '0;
        end else if (hit) begin
            any <= 1'b1;
            if (!any || page < lo) lo <= page;
            if (!any || page > hi) hi <= page;
        end
    end
endmodule

// File: rtl/dirty_scan.sv
module dirty_scan
    import dirty_scan_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                start,
    input  logic                                mode24_in,
    input  logic [LINE_W-1:0]                   height_in,
    output logic                                q_valid,
    output logic [LINE_W-PAGE_LINE_LOG2-1:0]    q_page,
    input  logic                                dirty8,
    input  logic                                dirty24,
    input  logic                                dirtyc,
    output logic                                upd_valid,
    input  logic                                upd_ready,
    output logic [LINE_W-1:0]                   upd_line,
    output logic [LINE_W:0]                     upd_lines,
    output logic                                clr_valid,
    output logic [LINE_W-PAGE_LINE_LOG2-1:0]    clr_lo,
    output logic [LINE_W-PAGE_LINE_LOG2-1:0]    clr_hi,
    output logic                                clr_mode24,
    output logic                                done
);
    localparam int PAGE_W = LINE_W - PAGE_LINE_LOG2;
    localparam int STEP_W = PAGE_W + 1;
    localparam int CNT_W  = LINE_W + 1;

    scan_state_t        state;
    logic [STEP_W-1:0]  step;
    logic [PAGE_W-1:0]  run_start;
    logic               run_open;
    logic               mode_q;
    logic [LINE_W-1:0]  height_q;
    logic [LINE_W-1:0]  upd_line_q;
    logic [CNT_W-1:0]   upd_cnt_q;

    logic [CNT_W-1:0]   h_round;
    logic [STEP_W-1:0]  nsteps;
    logic [STEP_W-1:0]  run_len;
    logic               step_live;
    logic               step_dirty;
    logic               span_any;
    logic               begin_scan;

    // Pages needed to cover the height, rounded up to whole pages.
    assign h_round    = CNT_W'(height_q) + CNT_W'(LINES_PER_PAGE - 1);
    assign nsteps     = STEP_W'(h_round >> PAGE_LINE_LOG2);
    assign step_live  = (state == S_SCAN) && (step < nsteps);
    assign run_len    = step - {1'b0, run_start};
    assign begin_scan = (state == S_IDLE) && start;

    dirty_scan_merge u_merge (
        .mode24 (mode_q),
        .d8     (dirty8),
        .d24    (dirty24),
        .dc     (dirtyc),
        .dirty  (step_dirty)
    );

    dirty_scan_span #(.PAGE_W(PAGE_W)) u_span (
        .clk   (clk),
        .rst   (rst),
        .clear (begin_scan),
        .hit   (step_live && step_dirty),
        .page  (step[PAGE_W-1:0]),
        .any   (span_any),
        .lo    (clr_lo),
        .hi    (clr_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            step       <= '0;
            run_start  <= '0;
            run_open   <= 1'b0;
            mode_q     <= 1'b0;
            height_q   <= '0;
            upd_line_q <= '0;
            upd_cnt_q  <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        state    <= S_SCAN;
                        step     <= '0;
                        run_open <= 1'b0;
                        mode_q   <= mode24_in;
                        height_q <= height_in;
                    end
                end
                S_SCAN: begin
                    if (step_live) begin
                        step <= step + 1'b1;
                        if (step_dirty && !run_open) begin
                            run_open  <= 1'b1;
                            run_start <= step[PAGE_W-1:0];
                        end else if (!step_dirty && run_open) begin
                            run_open   <= 1'b0;
                            upd_line_q <= {run_start, {PAGE_LINE_LOG2{1'b0}}};
                            upd_cnt_q  <= CNT_W'({run_len, {PAGE_LINE_LOG2{1'b0}}});
                            state      <= S_EMIT;
                        end
                    end else if (run_open) begin
                        // Flush the run that reached the bottom of the screen.
                        run_open   <= 1'b0;
                        upd_line_q <= {run_start, {PAGE_LINE_LOG2{1'b0}}};
                        upd_cnt_q  <= CNT_W'({run_len, {PAGE_LINE_LOG2{1'b0}}});
                        state      <= S_EMIT;
                    end else begin
                        state <= span_any ? S_CLEAR : S_DONE;
                    end
                end
                S_EMIT: begin
                    if (upd_ready) state <= S_SCAN;
                end
                S_CLEAR: state <= S_DONE;
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign q_valid    = step_live;
    assign q_page     = step[PAGE_W-1:0];
    assign upd_valid  = (state == S_EMIT);
    assign upd_line   = upd_line_q;
    assign upd_lines  = upd_cnt_q;
    assign clr_valid  = (state == S_CLEAR);
    assign clr_mode24 = mode_q;
    assign done       = (state == S_DONE);

endmodule

// File: rtl/dirty_scan_chk.sv
module dirty_scan_chk #(
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              q_valid,
    input logic [LINE_W-3:0] q_page,
    input logic              upd_valid,
    input logic              upd_ready,
    input logic [LINE_W-1:0] upd_line,
    input logic [LINE_W:0]   upd_lines,
    input logic              clr_valid,
    input logic [LINE_W-3:0] clr_lo,
    input logic [LINE_W-3:0] clr_hi,
    input logic              done
);
    AST_PAGE_ORDER: assert property (@(posedge clk) disable iff (rst)
        q_valid |=> (!q_valid || q_page == (LINE_W-2)'($past(q_page) + 1'b1))); // R2

    AST_UPD_SHAPE: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> (upd_lines != '0 && upd_lines[1:0] == 2'b00 && upd_line[1:0] == 2'b00)); // R4

    AST_STALL_NO_QUERY: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> !q_valid); // R6

    AST_UPD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_ready) |=> (upd_valid && $stable(upd_line) && $stable(upd_lines))); // R6

    AST_CLR_SPAN: assert property (@(posedge clk) disable iff (rst)
        clr_valid |-> (clr_lo <= clr_hi)); // R7

    AST_CLR_PULSE: assert property (@(posedge clk) disable iff (rst)
        clr_valid |=> (!clr_valid && done)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> (!upd_valid && !q_valid && !clr_valid)); // R8
endmodule

bind dirty_scan dirty_scan_chk #(.LINE_W(LINE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .q_valid   (q_valid),
    .q_page    (q_page),
    .upd_valid (upd_valid),
    .upd_ready (upd_ready),
    .upd_line  (upd_line),
    .upd_lines (upd_lines),
    .clr_valid (clr_valid),
    .clr_lo    (clr_lo),
    .clr_hi    (clr_hi),
    .done      (done)
);

// File: tb/dirty_scan_tb.sv
module dirty_scan_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 11;
    localparam int PW = LW - 2;
    localparam int NPG = 1 << PW;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic mode24_in = 1'b0;
    logic [LW-1:0] height_in = '0;
    logic q_valid;
    logic [PW-1:0] q_page;
    logic dirty8, dirty24, dirtyc;
    logic upd_valid;
    logic upd_ready = 1'b1;
    logic [LW-1:0] upd_line;
    logic [LW:0] upd_lines;
    logic clr_valid;
    logic [PW-1:0] clr_lo, clr_hi;
    logic clr_mode24;
    logic done;

    logic m8 [NPG];
    logic m24 [NPG];
    logic mc [NPG];

    assign dirty8  = m8[q_page];
    assign dirty24 = m24[q_page];
    assign dirtyc  = mc[q_page];

    always #(CLK_PERIOD/2) clk = ~clk;

    dirty_scan #(.LINE_W(LW)) u_dut (
        .clk(clk), .rst(rst), .start(start), .mode24_in(mode24_in),
        .height_in(height_in), .q_valid(q_valid), .q_page(q_page),
        .dirty8(dirty8), .dirty24(dirty24), .dirtyc(dirtyc),
        .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_line(upd_line),
        .upd_lines(upd_lines), .clr_valid(clr_valid), .clr_lo(clr_lo),
        .clr_hi(clr_hi), .clr_mode24(clr_mode24), .done(done)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit wd = 1'b0;

    // Expected outcome of the running scan
    int exp_line [300];
    int exp_cnt  [300];
    bit exp_fin  [300];
    int exp_n, exp_ns, exp_lo, exp_hi, cur_h;
    bit exp_any, exp_mode, bp_on, monitor_on;
    int q_exp, uidx, clr_seen;
    bit scan_done;
    bit prev_stall;
    int held_line, held_cnt;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (height=%0d)", tag, act, expv, cur_h);
        end
    endtask

    // Back-pressure pattern, changed just after the edge
    initial forever begin
        @(posedge clk);
        upd_ready <= bp_on ? ($urandom % 3 != 0) : 1'b1;
    end

    // Monitor, sampling at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) wd = 1'b1;
        if (!rst && monitor_on) begin
            if (q_valid) begin
                chk(int'(q_page) == q_exp, "R2 page order", int'(q_page), q_exp);
                q_exp++;
            end
            if (prev_stall)
                chk(upd_valid && int'(upd_line) == held_line && int'(upd_lines) == held_cnt,
                    "R6 held update", int'(upd_lines), held_cnt);
            prev_stall = 1'b0;
            if (upd_valid) begin
                chk(!q_valid, "R6 no query while stalled", int'(q_valid), 0);
                if (!upd_ready) begin
                    prev_stall = 1'b1;
                    held_line = int'(upd_line);
                    held_cnt = int'(upd_lines);
                end else if (uidx >= exp_n) begin
                    chk(1'b0, "R4 extra update", uidx, exp_n);
                    uidx++;
                end else begin
                    // Expected list was built with R3 merging and the mode sampled at start (R9)
                    chk(int'(upd_line) == exp_line[uidx], exp_fin[uidx] ? "R5 line" : "R4 line",
                        int'(upd_line), exp_line[uidx]);
                    chk(int'(upd_lines) == exp_cnt[uidx], exp_fin[uidx] ? "R5 count" : "R4 count",
                        int'(upd_lines), exp_cnt[uidx]);
                    uidx++;
                end
            end
            if (clr_valid) begin
                clr_seen++;
                chk(exp_any, "R7 unexpected clear", 1, int'(exp_any));
                chk(int'(clr_lo) == exp_lo, "R7 low page", int'(clr_lo), exp_lo);
                chk(int'(clr_hi) == exp_hi, "R7 high page", int'(clr_hi), exp_hi);
                chk(clr_mode24 == exp_mode, "R7 plane mode", int'(clr_mode24), int'(exp_mode));
            end
            if (done) begin
                chk(uidx == exp_n, "R3 update total", uidx, exp_n);
                chk(clr_seen == int'(exp_any), "R7 clear count", clr_seen, int'(exp_any));
                chk(q_exp == exp_ns, "R9 pages scanned", q_exp, exp_ns);
                if (cur_h == 0)
                    chk(q_exp == 0 && uidx == 0 && clr_seen == 0, "R10 empty scan", q_exp + uidx, 0);
                scan_done = 1'b1;
            end
        end
    end

    task automatic fill(input int kind, input bit mode);
        for (int s = 0; s < NPG; s++) begin
            case (kind)
                0: m8[s] = 1'b0;
                1: m8[s] = 1'b1;
                2: m8[s] = s[0];
                default: m8[s] = ($urandom % 3 == 0);
            endcase
            if (kind == 0) begin
                m24[s] = 1'b0;
                mc[s] = 1'b0;
            end else if (!mode) begin
                m24[s] = !m8[s];
                mc[s] = !m8[s];
            end else begin
                m24[s] = ($urandom % 5 == 0);
                mc[s] = ($urandom % 5 == 0);
            end
        end
    endtask

    task automatic run_scan(input int h, input bit mode, input int kind, input bit bp);
        bit open = 1'b0;
        int st = 0;
        bit d;
        fill(kind, mode);
        cur_h = h;
        exp_ns = (h + 3) / 4;
        exp_n = 0;
        exp_any = 1'b0;
        exp_lo = 0;
        exp_hi = 0;
        exp_mode = mode;
        for (int s = 0; s < exp_ns; s++) begin
            d = m8[s] | (mode & (m24[s] | mc[s]));
            if (d) begin
                if (!open) begin
                    open = 1'b1;
                    st = s;
                end
                if (!exp_any) exp_lo = s;
                exp_any = 1'b1;
                exp_hi = s;
            end else if (open) begin
                exp_line[exp_n] = st * 4;
                exp_cnt[exp_n] = (s - st) * 4;
                exp_fin[exp_n] = 1'b0;
                exp_n++;
                open = 1'b0;
            end
        end
        if (open) begin
            exp_line[exp_n] = st * 4;
            exp_cnt[exp_n] = (exp_ns - st) * 4;
            exp_fin[exp_n] = 1'b1;
            exp_n++;
        end
        q_exp = 0;
        uidx = 0;
        clr_seen = 0;
        scan_done = 1'b0;
        prev_stall = 1'b0;
        bp_on = bp;
        @(negedge clk);
        start = 1'b1;
        height_in = LW'(h);
        mode24_in = mode;
        @(negedge clk);
        start = 1'b0;
        height_in = ~LW'(h);          // R9: ignored after start
        mode24_in = !mode;
        if (exp_ns >= 4) begin
            start = 1'b1;             // R8: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (!scan_done && !wd) @(negedge clk);
    endtask

    initial begin
        exp_n = 0; exp_ns = 0; cur_h = 0; exp_any = 0; exp_mode = 0;
        bp_on = 0; monitor_on = 0;
        for (int s = 0; s < NPG; s++) begin
            m8[s] = 1'b0;
            m24[s] = 1'b0;
            mc[s] = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk(!q_valid && !upd_valid && !clr_valid && !done, "R1 during reset",
            int'(q_valid) + int'(upd_valid) + int'(clr_valid) + int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!q_valid && !upd_valid && !clr_valid && !done, "R1 after reset",
            int'(q_valid) + int'(upd_valid) + int'(clr_valid) + int'(done), 0);
        monitor_on = 1'b1;
        for (int h = 0; h <= 24 && !wd; h++)
            for (int k = 0; k < 4 && !wd; k++)
                for (int m = 0; m < 2 && !wd; m++)
                    run_scan(h, m[0], k, k[0]);
        for (int k = 0; k < 4 && !wd; k++) begin
            run_scan(100, 1'b1, k, 1'b1);
            run_scan(768, 1'b0, k, 1'b0);
            run_scan(2047, 1'b1, k, k[1]);
            run_scan(2047, 1'b0, k, 1'b1);
        end
        if (wd) chk(1'b0, "R8 watchdog expired", cyc, WD_LIMIT);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule